// File: doc/BRIEF.md
# Serial Receive Pattern-Match Synchronizer

This block sits between a serial receive bit source and a downstream byte FIFO. Each received bit arrives with a one-cycle strobe. The block hunts for a programmable 8-bit sync character. While it hunts, it passes no data downstream. When it finds the character, it writes that character out as the first byte. Every later group of eight bits follows as a byte, so the byte stream is aligned to the match and not to any fixed framing.

The search runs in one of two ways. In the sliding mode the character is tried at every bit position. In the aligned mode it is tried only where a window ends on an octet boundary. The octet reference starts at the first bit after the receiver is enabled. In time-slot mode, a slot-start marker redefines that reference. Two status outputs report the result: a lock flag, and a 3-bit code that gives the bit offset of the match from the octet boundary. The code is one less than the offset, modulo 8. When matching is turned off, the block locks on the first received bit with a fixed code of zero and passes data straight through.

Top module: `rx_pattern_sync`

## Requirements
- R1: While match_en is 1 and no match has been found, byte_valid stays 0.
- R2: In the cycle after the bit that completes a match, byte_valid is 1 and byte_data equals match_char. After that, a byte is produced after every further 8 received bits. Its value is the last 8 bits, with the first-received bit as the MSB.
- R3: With align_mode 0, the 8 most recent bits (the newest bit as the LSB) are compared with match_char at every received bit, once at least 8 bits have arrived since the receiver was enabled.
- R4: With align_mode 1, a match is accepted only when the completing bit sits at octet position 7. The offset code is then always 3'b111.
- R5: match_stat goes to 1 in the cycle after a match or forced lock. It then stays 1 while rx_en stays 1.
- R6: offset_code equals the octet position (0 to 7) of the bit that completed the match. An aligned match therefore reads 3'b111 and a one-bit offset reads 3'b000. The code holds while match_stat is 1.
- R7: With match_en 0, the first received bit of an unlocked search sets match_stat with offset_code 3'b000. Bytes then follow every 8 bits, counted from and including that bit.
- R8: Octet position 0 is the first bit received after rx_en rises. With slot_mode 1, a bit that arrives with slot_start 1 is position 0. Positions count up by one per received bit, modulo 8.
- R9: Synchronous rst, or rx_en at 0, clears match_stat, offset_code, byte_valid and all bit counting in the next cycle. Bits strobed while rx_en is 0 are ignored.
- R10: If match_en falls while a search is unlocked, the next received bit locks the block as in R7.
- R11: All outputs are registered and change only in the cycle after a strobed bit. byte_valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low clears and restarts the search |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| rx_bit | input | 1 | Received serial data bit |
| match_en | input | 1 | 1: hunt for match_char; 0: pass data from the first bit |
| align_mode | input | 1 | 0: sliding search; 1: octet-boundary-only search |
| slot_mode | input | 1 | 1: slot_start defines the octet reference |
| slot_start | input | 1 | Marks the current strobed bit as octet position 0 |
| match_char | input | 8 | Sync character to hunt for |
| byte_valid | output | 1 | Byte output strobe |
| byte_data | output | 8 | Assembled byte |
| match_stat | output | 1 | Lock flag |
| offset_code | output | 3 | Match offset code (offset minus one, modulo 8) |

## Verification
The checker assumes three things about the inputs. match_char stays constant during a search. slot_start is meaningful only together with bit_stb. Strobed bits arrive no more often than once per clock, so the byte pulse after a match cannot merge with the next byte. The bench keeps to these rules: it changes match_char only while rx_en is low or rst is high, and it raises slot_start only in cycles that also carry a bit strobe. It also inserts idle cycles between bits, so the single-cycle byte pulse and the registered status can be observed when no bit arrives.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} rps_state_e;
endpackage

// File: rtl/rps_shift.sv
module rps_shift #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         stb,
  input  logic         din,
  output logic [W-1:0] win_nx,
  output logic         full_nx
);
  localparam logic [CW:0] FILL_MAX = (CW+1)'(W);
  localparam logic [CW:0] FILL_M1  = (CW+1)'(W-1);

  logic [W-1:0] sr_q;
  logic [CW:0]  fill_q;

  assign win_nx  = {sr_q[W-2:0], din};
  assign full_nx = (fill_q >= FILL_M1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (stb) begin
      sr_q <= win_nx;
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/rps_octet_pos.sv
module rps_octet_pos #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          stb,
  input  logic          slot_mode,
  input  logic          slot_start,
  output logic [CW-1:0] pos_c
);
  logic [CW-1:0] pos_q;

  assign pos_c = (slot_mode && slot_start) ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  pos_q <= '0;
    else if (stb)    pos_q <= pos_c + CW'(1);
  end
endmodule

// File: rtl/rps_detect.sv
module rps_detect #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  win,
  input  logic          full,
  input  logic [CW-1:0] pos,
  input  logic          align_mode,
  input  logic [W-1:0]  pattern,
  output logic          hit
);
  localparam logic [CW-1:0] LAST_POS = CW'(W-1);

  logic eq;
  logic at_boundary;

  assign eq          = (win == pattern);
  assign at_boundary = (pos == LAST_POS);
  assign hit         = full && eq && (!align_mode || at_boundary);
endmodule

// File: rtl/rx_pattern_sync.sv
module rx_pattern_sync #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          bit_stb,
  input  logic          rx_bit,
  input  logic          match_en,
  input  logic          align_mode,
  input  logic          slot_mode,
  input  logic          slot_start,
  input  logic [W-1:0]  match_char,
  output logic          byte_valid,
  output logic [W-1:0]  byte_data,
  output logic          match_stat,
  output logic [CW-1:0] offset_code
);
  import rps_pkg::*;

  localparam logic [CW-1:0] BCNT_LAST = CW'(W-1);

  logic          clr;
  logic          stb;
  logic [W-1:0]  win_nx;
  logic          full_nx;
  logic [CW-1:0] pos_c;
  logic          hit;

  rps_state_e    state_q;
  logic [CW-1:0] bcnt_q;

  assign clr = !rx_en;
  assign stb = rx_en && bit_stb;

  rps_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .clr(clr), .stb(stb), .din(rx_bit),
    .win_nx(win_nx), .full_nx(full_nx)
  );

  rps_octet_pos #(.W(W)) u_pos (
    .clk(clk), .rst(rst), .clr(clr), .stb(stb),
    .slot_mode(slot_mode), .slot_start(slot_start), .pos_c(pos_c)
  );

  rps_detect #(.W(W)) u_det (
    .win(win_nx), .full(full_nx), .pos(pos_c), .align_mode(align_mode),
    .pattern(match_char), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q     <= ST_HUNT;
      bcnt_q      <= '0;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
      match_stat  <= 1'b0;
      offset_code <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (stb) begin
        unique case (state_q)
          ST_HUNT: begin
            if (!match_en) begin
              state_q     <= ST_LOCK;
              match_stat  <= 1'b1;
              offset_code <= '0;
              bcnt_q      <= CW'(1);
            end else if (hit) begin
              state_q     <= ST_LOCK;
              match_stat  <= 1'b1;
              offset_code <= pos_c;
              byte_valid  <= 1'b1;
              byte_data   <= win_nx;
              bcnt_q      <= '0;
            end
          end
          ST_LOCK: begin
            if (bcnt_q == BCNT_LAST) begin
              byte_valid <= 1'b1;
              byte_data  <= win_nx;
              bcnt_q     <= '0;
            end else begin
              bcnt_q <= bcnt_q + CW'(1);
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_en,
  input logic          bit_stb,
  input logic          match_en,
  input logic          align_mode,
  input logic [W-1:0]  match_char,
  input logic          byte_valid,
  input logic [W-1:0]  byte_data,
  input logic          match_stat,
  input logic [CW-1:0] offset_code
);
  AST_NO_EARLY_BYTE: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> match_stat); // R1
  AST_LOCK_BYTE: assert property (@(posedge clk) disable iff (rst)
    (rx_en && bit_stb && !match_stat && match_en) |=>
      ((match_stat == byte_valid) && (!byte_valid || byte_data == $past(match_char)))); // R2
  AST_ALIGNED_CODE: assert property (@(posedge clk) disable iff (rst)
    (rx_en && bit_stb && !match_stat && match_en && align_mode) |=>
      (!match_stat || offset_code == {CW{1'b1}})); // R4
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (match_stat && rx_en) |=> match_stat); // R5
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (match_stat && rx_en) |=> $stable(offset_code)); // R6
  AST_FORCED_LOCK: assert property (@(posedge clk) disable iff (rst)
    (rx_en && bit_stb && !match_stat && !match_en) |=>
      (match_stat && offset_code == '0)); // R7
  AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!match_stat && !byte_valid && offset_code == '0)); // R9
  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid); // R11
endmodule

bind rx_pattern_sync rps_checker #(.W(W)) u_chk (.*);

// File: tb/tb_rx_pattern_sync.sv
`timescale 1ns/1ps
module tb_rx_pattern_sync;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, bit_stb = 1'b0, rx_bit = 1'b0;
  logic match_en = 1'b1, align_mode = 1'b0, slot_mode = 1'b0, slot_start = 1'b0;
  logic [7:0] match_char = 8'hA5;
  logic       byte_valid, match_stat;
  logic [7:0] byte_data;
  logic [2:0] offset_code;

  int vectors = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench reference state
  logic [7:0] m_sr;
  int m_fill, m_pos, m_cnt;
  bit m_lock;
  logic [2:0] e_code;
  bit e_stat, e_bv;
  logic [7:0] e_byte;

  always #4 clk = ~clk;

  rx_pattern_sync dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .match_en(match_en), .align_mode(align_mode), .slot_mode(slot_mode),
    .slot_start(slot_start), .match_char(match_char),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .match_stat(match_stat), .offset_code(offset_code)
  );

  task automatic cmp(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_sr = 8'h00; m_fill = 0; m_pos = 0; m_cnt = 0; m_lock = 0;
    e_code = 3'd0; e_stat = 0; e_bv = 0; e_byte = e_byte;
  endtask

  // expected outputs after one clock edge with the currently driven inputs
  task automatic model_edge();
    logic [7:0] w;
    int p;
    e_bv = 0;
    if (rst || !rx_en) begin
      model_clear();
      e_byte = 8'h00;
      return;
    end
    if (!bit_stb) return;
    p = (slot_mode && slot_start) ? 0 : m_pos;          // R8
    m_pos = (p + 1) % 8;
    w = {m_sr[6:0], rx_bit};
    if (m_fill < 8) m_fill++;
    if (!m_lock) begin
      if (!match_en) begin                              // R7 R10
        m_lock = 1; e_stat = 1; e_code = 3'd0; m_cnt = 1;
      end else if (m_fill == 8 && w == match_char && (!align_mode || p == 7)) begin // R3 R4
        m_lock = 1; e_stat = 1; e_code = 3'(p); e_bv = 1; e_byte = w; m_cnt = 0;
      end
    end else begin
      m_cnt++;
      if (m_cnt == 8) begin e_bv = 1; e_byte = w; m_cnt = 0; end
    end
    m_sr = w;
  endtask

  task automatic check_outs();
    cmp("R5 match_stat", match_stat, e_stat);
    cmp("R6 offset_code", offset_code, e_code);
    cmp("R11 byte_valid", byte_valid, e_bv);
    if (e_bv) cmp("R2 byte_data", byte_data, e_byte);
  endtask

  task automatic step(input bit stb, input bit b, input bit ss);
    bit_stb = stb; rx_bit = b; slot_start = ss;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    bit_stb = 1'b0; slot_start = 1'b0;
    check_outs();
  endtask

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic restart();
    rx_en = 1'b0;
    step(0, 0, 0);
    rx_en = 1'b1;
  endtask

  // prefix bits, then the character MSB first, then random tail
  task automatic run_stream(input int pre, input int tail);
    for (int i = 0; i < pre; i++) step(1, next_rand(), 0);
    for (int i = 7; i >= 0; i--) step(1, match_char[i], 0);
    for (int i = 0; i < tail; i++) begin
      step(1, next_rand(), 0);
      if (i % 5 == 4) step(0, 0, 0);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] chars [4];
    chars[0] = 8'hA5; chars[1] = 8'h3C; chars[2] = 8'h7E; chars[3] = 8'h00;
    model_clear(); e_byte = 8'h00;
    @(negedge clk);
    step(0, 0, 0); step(0, 0, 0);
    // reset state (R9)
    cmp("R9 reset match_stat", match_stat, 0);
    cmp("R9 reset offset_code", offset_code, 0);
    cmp("R9 reset byte_valid", byte_valid, 0);
    rst = 1'b0;

    // directed: sliding, three zeros then A5 ends at position 10 -> code 2 (R3 R6)
    match_char = 8'hA5; align_mode = 0; match_en = 1;
    restart();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    for (int i = 7; i >= 0; i--) begin
      step(1, match_char[i], 0);
      if (i > 0) cmp("R1 no byte before match", byte_valid, 0);
    end
    cmp("R6 sliding offset code", offset_code, 3'd2);
    cmp("R2 matched byte", byte_data, 8'hA5);
    // bits ignored while disabled, state cleared (R9)
    rx_en = 1'b0;
    step(1, 1, 0);
    cmp("R9 disable clears stat", match_stat, 0);
    step(1, 0, 0);
    cmp("R9 disable clears code", offset_code, 0);
    rx_en = 1'b1;

    // directed: aligned, same offset must not match; aligned copy matches (R4)
    align_mode = 1;
    restart();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    for (int i = 7; i >= 0; i--) step(1, match_char[i], 0);
    cmp("R4 unaligned rejected", match_stat, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    for (int i = 7; i >= 0; i--) step(1, match_char[i], 0);
    cmp("R4 aligned accepted", match_stat, 1);
    cmp("R4 aligned code", offset_code, 3'b111);

    // sweep: both search modes, four characters, eight prefix offsets
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 4; c++)
        for (int pre = 0; pre < 8; pre++) begin
          align_mode = a[0]; match_char = chars[c]; match_en = 1;
          restart();
          run_stream(pre + 8 * a, 30);
        end

    // forced lock with matching off (R7)
    match_en = 0; align_mode = 0;
    for (int pre = 0; pre < 3; pre++) begin
      restart();
      for (int i = 0; i < pre; i++) step(0, 0, 0);
      step(1, 1, 0);
      cmp("R7 forced stat", match_stat, 1);
      cmp("R7 forced code", offset_code, 0);
      run_stream(pre, 20);
    end

    // match_en dropped mid-search (R10)
    match_en = 1; match_char = 8'hA5;
    restart();
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    match_en = 0;
    step(1, 1, 0);
    cmp("R10 lock after match_en drop", match_stat, 1);
    cmp("R10 code after match_en drop", offset_code, 0);
    for (int i = 0; i < 20; i++) step(1, next_rand(), 0);

    // slot reference (R8), slot marker at several phases
    match_en = 1; slot_mode = 1;
    for (int a = 0; a < 2; a++)
      for (int ph = 0; ph < 8; ph++) begin
        align_mode = a[0]; match_char = 8'h3C;
        restart();
        for (int i = 0; i < 48; i++) begin
          bit b;
          b = (i >= ph + 8 && i < ph + 16) ? match_char[7 - (i - ph - 8)] : next_rand();
          step(1, b, (i % 8) == ph);
        end
      end
    slot_mode = 0;

    // synchronous reset mid-stream (R9)
    match_en = 0;
    restart();
    for (int i = 0; i < 4; i++) step(1, 1, 0);
    rst = 1'b1;
    step(1, 1, 0);
    cmp("R9 rst clears stat", match_stat, 0);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) step(1, next_rand(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule